// File: doc/BRIEF.md
# Edge-Aligned PWM Timer Channel

This block is a 16-bit up-counting timer with a single compare channel that drives an edge-aligned pulse-width-modulated output. A selectable clock divider paces the counter, which runs from zero to a programmable modulus and then wraps, so each PWM period spans modulus plus one counter ticks. The channel compares the count against an active duty value. The output polarity can be chosen, and a compare match raises a sticky flag with an optional interrupt request.

Software reaches the block through an 8-bit register bus. The 16-bit duty value is written one byte at a time into a staging buffer and only moves to the active compare register at a safe point. That point comes at once when the counter clock is off. When the counter runs, it comes at the step from modulus minus one to modulus, so a pulse never sees half of an old value and half of a new one. A write to the channel status/control register discards a half-written byte pair.

Register map (byte addresses): 0 timer control (bits 4:3 clock select, bits 2:0 divider exponent); 1 modulus high byte; 2 modulus low byte; 3 channel status/control (bit 7 compare flag, bit 6 interrupt enable, bit 5 polarity); 4 duty high byte; 5 duty low byte. Reading any other address returns zero. Writes take effect at the clock edge where `bus_wr` is high.

Top module: `epwm_timer`

## Requirements
- R1: With clock select (control bits 4:3) nonzero, each counter tick advances the count by one, and a tick taken at the modulus value returns it to zero. With clock select 0, the count holds its value.
- R2: The divider exponent `d` (control bits 2:0) makes a counter tick occur once every 2^d clock cycles while the clock select is nonzero. The divider phase restarts from zero whenever the clock select is 0.
- R3: With polarity (channel bit 5) at 0, `pwm_out` is high while the count is below the active duty value and low otherwise. With polarity at 1, the output is the inverse.
- R4: An active duty value of 0x0000 gives a constant inactive level (0% duty). An active duty value above the modulus gives a constant active level (100% duty).
- R5: Writes to addresses 4 and 5, in either order, only load the staging buffer. The active duty value does not change until both bytes have been written since the last transfer or discard.
- R6: With clock select 0, the write that completes the byte pair loads the active duty value at that same clock edge.
- R7: With clock select nonzero, a completed pair transfers on the counter tick that moves the count from modulus minus one to modulus. A pair completed by a write at that same edge waits for the next such step.
- R8: Any write to address 3 clears both byte-written markers, which discards a half-written pair. A pair already complete before the transfer edge still transfers when that write falls on the edge.
- R9: A counter tick that brings the count equal to the active duty value sets the compare flag (channel bit 7). Writing 1 to bit 7 clears it, and a set in the same cycle takes precedence.
- R10: `cmp_irq` is high exactly when the compare flag and the interrupt enable (channel bit 6) are both 1.
- R11: After reset the count, the active and buffered duty values, the flag, the control fields and the polarity are zero, and the modulus is 0xFFFF. `pwm_out` and `cmp_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pwm_out | output | 1 | Edge-aligned PWM output |
| cmp_irq | output | 1 | Compare interrupt request |

## Verification
The duty-value transfer at the step from modulus minus one to modulus can fall in the same cycle as a write that touches the coherency markers. One such write completes the byte pair; another is a status/control write that discards the markers. The bench runs the divider at ratio 1 so every cycle is a tick, waits until the counter sits at modulus minus one, and then issues that write in exactly that cycle. A lockstep reference model built from the requirements judges the result each cycle through the PWM output, the interrupt line and the read data. The model expects the completing write to defer the transfer by one period, and the complete pair to transfer despite the discard.

// File: rtl/epwm_pkg.sv
package epwm_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DIV_W  = 3;
  localparam int unsigned PRE_W  = (1 << DIV_W) - 1;
  localparam int unsigned CSEL_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_MODH = 3'd1,
    A_MODL = 3'd2,
    A_CHSC = 3'd3,
    A_VALH = 3'd4,
    A_VALL = 3'd5
  } reg_addr_e;

  localparam int unsigned B_FLAG = 7;
  localparam int unsigned B_IEN  = 6;
  localparam int unsigned B_POL  = 5;
endpackage

// File: rtl/epwm_prescaler.sv
module epwm_prescaler #(
  parameter int unsigned DIV_W = epwm_pkg::DIV_W,
  parameter int unsigned PRE_W = epwm_pkg::PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q, pre_d, mask;

  always_comb begin
    mask   = (PRE_W'(1) << div_i) - PRE_W'(1);
    tick_o = run_i && ((pre_q & mask) == mask);
    pre_d  = run_i ? pre_q + PRE_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R2: a divided tick is never followed directly by another one
  p_div_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/epwm_counter.sv
module epwm_counter #(
  parameter int unsigned CNT_W = epwm_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             to_mod_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) begin
      if (cnt_q == mod_i) cnt_d = '0;
      else                cnt_d = cnt_q + CNT_W'(1);
    end
    to_mod_o = tick_i && (cnt_q == mod_i - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;

  // R1: stopped clock holds the count
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(cnt_q));
  // R1: a tick at the modulus wraps to zero
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && cnt_q == mod_i) |=> (cnt_q == '0));
endmodule

// File: rtl/epwm_channel.sv
module epwm_channel #(
  parameter int unsigned CNT_W  = epwm_pkg::CNT_W,
  parameter int unsigned BYTE_W = epwm_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cnt_nxt_i,
  input  logic [CNT_W-1:0]  mod_i,
  input  logic              to_mod_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              sc_wr_i,
  input  logic              flag_clr_i,
  input  logic              pol_i,
  input  logic              ien_i,
  output logic              pwm_o,
  output logic              irq_o,
  output logic              flag_o,
  output logic [CNT_W-1:0]  buf_o
);
  logic [BYTE_W-1:0] buf_hi_q, buf_hi_d, buf_lo_q, buf_lo_d;
  logic              mk_hi_q, mk_hi_d, mk_lo_q, mk_lo_d;
  logic [CNT_W-1:0]  act_q, act_d;
  logic              flag_q, flag_d;
  logic              xfer_run, xfer_now, match;

  always_comb begin
    buf_hi_d = wr_hi_i ? wdata_i : buf_hi_q;
    buf_lo_d = wr_lo_i ? wdata_i : buf_lo_q;
    xfer_run = to_mod_i && mk_hi_q && mk_lo_q;
    xfer_now = !run_i && ((wr_hi_i && mk_lo_q) || (wr_lo_i && mk_hi_q));

    act_d = act_q;
    if (xfer_now)      act_d = {buf_hi_d, buf_lo_d};
    else if (xfer_run) act_d = {buf_hi_q, buf_lo_q};

    mk_hi_d = mk_hi_q;
    mk_lo_d = mk_lo_q;
    if (xfer_run || xfer_now) begin
      mk_hi_d = 1'b0;
      mk_lo_d = 1'b0;
    end
    if (wr_hi_i && !xfer_now) mk_hi_d = 1'b1;
    if (wr_lo_i && !xfer_now) mk_lo_d = 1'b1;
    if (sc_wr_i) begin
      mk_hi_d = 1'b0;
      mk_lo_d = 1'b0;
    end

    match  = tick_i && (cnt_nxt_i == act_q);
    flag_d = flag_q;
    if (flag_clr_i) flag_d = 1'b0;
    if (match)      flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_hi_q <= '0;
      buf_lo_q <= '0;
      mk_hi_q  <= 1'b0;
      mk_lo_q  <= 1'b0;
      act_q    <= '0;
      flag_q   <= 1'b0;
    end else begin
      buf_hi_q <= buf_hi_d;
      buf_lo_q <= buf_lo_d;
      mk_hi_q  <= mk_hi_d;
      mk_lo_q  <= mk_lo_d;
      act_q    <= act_d;
      flag_q   <= flag_d;
    end
  end

  assign pwm_o  = (cnt_i < act_q) ^ pol_i;
  assign irq_o  = flag_q & ien_i;
  assign flag_o = flag_q;
  assign buf_o  = {buf_hi_q, buf_lo_q};

  // R7: a running transfer lands only on the step into the modulus
  p_xfer_point_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_i) && act_q != $past(act_q)) |-> ($past(cnt_i) == $past(mod_i) - CNT_W'(1)));
  // R8: status/control write leaves no half pair behind
  p_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr_i |=> (!mk_hi_q && !mk_lo_q));
  // R9: a match always leaves the flag set
  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag_q);
  // R5: active value unchanged without a completed pair
  p_no_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mk_hi_q && !mk_lo_q) |=> $stable(act_q));
endmodule

// File: rtl/epwm_timer.sv
module epwm_timer
  import epwm_pkg::*;
#(
  parameter int unsigned P_CNT_W  = CNT_W,
  parameter int unsigned P_BYTE_W = BYTE_W,
  parameter int unsigned P_ADDR_W = ADDR_W,
  parameter int unsigned P_DIV_W  = DIV_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [P_ADDR_W-1:0] bus_addr,
  input  logic [P_BYTE_W-1:0] bus_wdata,
  output logic [P_BYTE_W-1:0] bus_rdata,
  output logic                pwm_out,
  output logic                cmp_irq
);
  localparam int unsigned P_PRE_W = (1 << P_DIV_W) - 1;

  logic [CSEL_W-1:0]  csel_q, csel_d;
  logic [P_DIV_W-1:0] div_q, div_d;
  logic [P_CNT_W-1:0] mod_q, mod_d;
  logic               pol_q, pol_d, ien_q, ien_d;
  logic               run, tick, to_mod, flag;
  logic [P_CNT_W-1:0] cnt, cnt_nxt, bufv;
  logic               wr_ctrl, wr_modh, wr_modl, wr_chsc, wr_valh, wr_vall;

  always_comb begin
    wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    wr_modh = bus_wr && (bus_addr == A_MODH);
    wr_modl = bus_wr && (bus_addr == A_MODL);
    wr_chsc = bus_wr && (bus_addr == A_CHSC);
    wr_valh = bus_wr && (bus_addr == A_VALH);
    wr_vall = bus_wr && (bus_addr == A_VALL);

    csel_d = wr_ctrl ? bus_wdata[P_DIV_W +: CSEL_W] : csel_q;
    div_d  = wr_ctrl ? bus_wdata[P_DIV_W-1:0]       : div_q;
    mod_d  = mod_q;
    if (wr_modh) mod_d[P_CNT_W-1:P_BYTE_W] = bus_wdata;
    if (wr_modl) mod_d[P_BYTE_W-1:0]       = bus_wdata;
    pol_d  = wr_chsc ? bus_wdata[B_POL] : pol_q;
    ien_d  = wr_chsc ? bus_wdata[B_IEN] : ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csel_q <= '0;
      div_q  <= '0;
      mod_q  <= '1;
      pol_q  <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      csel_q <= csel_d;
      div_q  <= div_d;
      mod_q  <= mod_d;
      pol_q  <= pol_d;
      ien_q  <= ien_d;
    end
  end

  assign run = |csel_q;

  epwm_prescaler #(.DIV_W(P_DIV_W), .PRE_W(P_PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(run), .div_i(div_q), .tick_o(tick)
  );

  epwm_counter #(.CNT_W(P_CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick), .mod_i(mod_q),
    .cnt_o(cnt), .cnt_nxt_o(cnt_nxt), .to_mod_o(to_mod)
  );

  epwm_channel #(.CNT_W(P_CNT_W), .BYTE_W(P_BYTE_W)) u_ch (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick),
    .cnt_i(cnt), .cnt_nxt_i(cnt_nxt), .mod_i(mod_q), .to_mod_i(to_mod),
    .wr_hi_i(wr_valh), .wr_lo_i(wr_vall), .wdata_i(bus_wdata),
    .sc_wr_i(wr_chsc), .flag_clr_i(wr_chsc && bus_wdata[B_FLAG]),
    .pol_i(pol_q), .ien_i(ien_q),
    .pwm_o(pwm_out), .irq_o(cmp_irq), .flag_o(flag), .buf_o(bufv)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata = P_BYTE_W'({csel_q, div_q});
      A_MODH: bus_rdata = mod_q[P_CNT_W-1:P_BYTE_W];
      A_MODL: bus_rdata = mod_q[P_BYTE_W-1:0];
      A_CHSC: begin
        bus_rdata[B_FLAG] = flag;
        bus_rdata[B_IEN]  = ien_q;
        bus_rdata[B_POL]  = pol_q;
      end
      A_VALH: bus_rdata = bufv[P_CNT_W-1:P_BYTE_W];
      A_VALL: bus_rdata = bufv[P_BYTE_W-1:0];
      default: bus_rdata = '0;
    endcase
  end

  // R10: interrupt follows flag and enable
  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_irq |-> (bus_addr != A_CHSC || (bus_rdata[B_FLAG] && bus_rdata[B_IEN])));
endmodule

// File: tb/epwm_timer_bench.sv
`timescale 1ns/1ps
module epwm_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       pwm_out, cmp_irq;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  epwm_timer u_epwm_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .cmp_irq(cmp_irq)
  );

  // reference model state, built from the requirements
  logic [1:0]  m_csel;
  logic [2:0]  m_div;
  logic [6:0]  m_pre;
  logic [15:0] m_mod, m_cnt, m_act;
  logic [7:0]  m_bh, m_bl;
  logic        m_mh, m_ml, m_flag, m_ien, m_pol;

  task automatic model_reset();
    m_csel = 0; m_div = 0; m_pre = 0; m_mod = 16'hFFFF; m_cnt = 0; m_act = 0;
    m_bh = 0; m_bl = 0; m_mh = 0; m_ml = 0; m_flag = 0; m_ien = 0; m_pol = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin : step
      logic run, tk, xr, im, mt;
      logic [6:0] mask;
      logic [15:0] cn;
      run  = (m_csel != 0);
      mask = 7'((8'd1 << m_div) - 8'd1);
      tk   = run && ((m_pre & mask) == mask);
      cn   = tk ? ((m_cnt == m_mod) ? 16'd0 : m_cnt + 16'd1) : m_cnt;
      xr   = tk && m_mh && m_ml && (m_cnt == m_mod - 16'd1);
      mt   = tk && (cn == m_act);
      im   = bus_wr && !run && ((bus_addr == 3'd4 && m_ml) || (bus_addr == 3'd5 && m_mh));
      if (bus_wr && bus_addr == 3'd3 && bus_wdata[7]) m_flag = 0;
      if (mt) m_flag = 1;
      if (im) m_act = (bus_addr == 3'd4) ? {bus_wdata, m_bl} : {m_bh, bus_wdata};
      else if (xr) m_act = {m_bh, m_bl};
      if (xr || im) begin m_mh = 0; m_ml = 0; end
      if (bus_wr && bus_addr == 3'd4 && !im) m_mh = 1;
      if (bus_wr && bus_addr == 3'd5 && !im) m_ml = 1;
      if (bus_wr && bus_addr == 3'd3) begin m_mh = 0; m_ml = 0; end
      if (bus_wr) begin
        case (bus_addr)
          3'd0: begin m_csel = bus_wdata[4:3]; m_div = bus_wdata[2:0]; end
          3'd1: m_mod[15:8] = bus_wdata;
          3'd2: m_mod[7:0]  = bus_wdata;
          3'd3: begin m_ien = bus_wdata[6]; m_pol = bus_wdata[5]; end
          3'd4: m_bh = bus_wdata;
          3'd5: m_bl = bus_wdata;
          default: ;
        endcase
      end
      m_pre = run ? m_pre + 7'd1 : 7'd0;
      m_cnt = cn;
    end
  end

  function automatic logic exp_pwm();
    return (m_cnt < m_act) ^ m_pol;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {3'b0, m_csel, m_div};
      3'd1: return m_mod[15:8];
      3'd2: return m_mod[7:0];
      3'd3: return {m_flag, m_ien, m_pol, 5'b0};
      3'd4: return m_bh;
      3'd5: return m_bl;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check1(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check1(tag, "pwm_out", 16'(pwm_out), 16'(exp_pwm()));
    check1("R10", "cmp_irq", 16'(cmp_irq), 16'(m_flag & m_ien));
    check1(tag, "bus_rdata", 16'(bus_rdata), 16'(exp_rd(bus_addr)));
  endtask

  task automatic drive(input string tag, input logic w, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    compare(tag);
    bus_wr = w; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input string tag, input int n, input logic [2:0] a);
    for (int i = 0; i < n; i++) drive(tag, 1'b0, a, 8'h00);
  endtask

  // issue a write in the cycle whose counter state equals v
  task automatic drive_when(input string tag, input logic [15:0] v, input logic [2:0] a, input logic [7:0] d);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      compare(tag);
      if (m_cnt == v) begin
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        return;
      end
      bus_wr = 1'b0; bus_addr = 3'd3;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nvec++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h0000_5EED);
    model_reset();
    repeat (3) @(negedge clk);
    // R11: reset state at the ports
    check1("R11", "pwm_out", 16'(pwm_out), 16'h0);
    check1("R11", "cmp_irq", 16'(cmp_irq), 16'h0);
    bus_addr = 3'd1; #1;
    check1("R11", "mod high", 16'(bus_rdata), 16'hFF);
    bus_addr = 3'd3; #1;
    check1("R11", "chsc", 16'(bus_rdata), 16'h00);
    @(negedge clk); rst_n = 1'b1;

    // setup with clock stopped: immediate transfer
    drive("R11", 1, 3'd1, 8'h00);
    drive("R1", 1, 3'd2, 8'h05);
    drive("R6", 1, 3'd5, 8'h03);
    drive("R6", 1, 3'd4, 8'h00);
    idle("R6", 3, 3'd3);
    // counting, ratio 1 then 4
    drive("R1", 1, 3'd0, 8'b000_01_000);
    idle("R1", 30, 3'd0);
    drive("R2", 1, 3'd0, 8'b000_01_010);
    idle("R2", 50, 3'd0);
    drive("R2", 1, 3'd0, 8'b000_10_111);
    idle("R2", 300, 3'd3);
    drive("R1", 1, 3'd0, 8'b000_00_000);
    idle("R1", 10, 3'd0);
    // polarity inverted
    drive("R3", 1, 3'd3, 8'h20);
    drive("R3", 1, 3'd0, 8'b000_01_000);
    idle("R3", 20, 3'd3);
    // 0% and 100% with stopped-clock loads
    drive("R4", 1, 3'd0, 8'h00);
    drive("R4", 1, 3'd3, 8'h00);
    drive("R6", 1, 3'd4, 8'h00);
    drive("R6", 1, 3'd5, 8'h00);
    drive("R4", 1, 3'd0, 8'b000_01_000);
    idle("R4", 20, 3'd3);
    drive("R4", 1, 3'd0, 8'h00);
    drive("R6", 1, 3'd5, 8'h06);
    drive("R6", 1, 3'd4, 8'h00);
    drive("R4", 1, 3'd0, 8'b000_11_000);
    idle("R4", 20, 3'd3);
    // half pair while running has no effect
    drive("R5", 1, 3'd5, 8'h02);
    idle("R5", 25, 3'd5);
    drive("R7", 1, 3'd4, 8'h00);
    idle("R7", 25, 3'd3);
    // discard of a half pair
    drive("R8", 1, 3'd4, 8'h00);
    drive("R8", 1, 3'd3, 8'h00);
    drive("R8", 1, 3'd5, 8'h04);
    idle("R8", 25, 3'd4);
    // collision: completing write at the step into the modulus
    drive("R7", 1, 3'd4, 8'h00);
    drive_when("R7", 16'd4, 3'd5, 8'h01);
    idle("R7", 20, 3'd5);
    // collision: discard at the step into the modulus with complete pair
    drive_when("R8", 16'd1, 3'd4, 8'h00);
    drive("R8", 1, 3'd5, 8'h02);
    drive_when("R8", 16'd4, 3'd3, 8'h40);
    idle("R8", 20, 3'd3);
    // flag and interrupt, clear and re-set
    idle("R9", 10, 3'd3);
    drive("R9", 1, 3'd3, 8'hC0);
    idle("R9", 3, 3'd3);
    drive_when("R9", 16'd1, 3'd3, 8'hC0);
    idle("R10", 10, 3'd3);
    drive("R10", 1, 3'd3, 8'h80);
    idle("R10", 10, 3'd3);

    // constrained random
    for (int k = 0; k < 3000; k++) begin : rnd
      logic [2:0] a;
      logic [7:0] d;
      logic w;
      a = 3'($urandom_range(0, 6));
      d = 8'($urandom());
      w = ($urandom_range(0, 3) == 0);
      if (a == 3'd1) d = 8'h00;
      if (a == 3'd2) d = 8'($urandom_range(0, 12));
      if (a == 3'd4) d = ($urandom_range(0, 3) == 0) ? 8'h01 : 8'h00;
      if (a == 3'd5) d = 8'($urandom_range(0, 14));
      if (a == 3'd0) d = {3'b0, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 2))};
      drive("R9", w, a, d);
    end
    idle("R9", 2, 3'd3);
    finish_run();
  end
endmodule